// File: doc/BRIEF.md
# Integrating Pulse Counter with Periodic Reporting

The block counts rising edges of an asynchronous binary pulse input in a wrapping accumulator. At the end of every integration cycle it publishes the current total on a report port. The cycle length is picked from a menu of sixteen durations and timed in one-second steps by a tick enable supplied from outside. An operator can also request an extra reading by holding a transmit-request line high for longer than one second.

Each report is marked by a one-cycle strobe and carries quality information. NEW_VAL-style change indication (`new_val`) pulses when the total differs from the previous report. `restart` is set when the report does not cover one complete, wrap-free integration cycle. The level outputs `blocked` and `invalid` follow the block command and the health of the binary input module.

Top module: `pulse_integrator`

## Requirements
- R1: Each rising edge of `pulse_in`, after a two-flop synchronizer, adds one to the accumulator while counting is enabled.
- R2: While `block_cmd` or `mod_inop` is high, `blocked` is high, the accumulator holds, and the cycle timer is held at zero, so no periodic report is issued.
- R3: A periodic report is issued every P ticks of `tick_1s`. P is selected by `cycle_sel` as follows: 0→30, 1→60, 2→90, 3→120, 4→150, 5→180, 6→240, 7→300, 8→360, 9→450, 10→600, 11→720, 12→900, 13→1200, 14→1800, 15→3600.
- R4: A report is a one-cycle `rep_strobe`, with `rep_value` equal to the accumulated count; `rep_value` holds until the next report.
- R5: `new_val` pulses only together with `rep_strobe`, and only when `rep_value` differs from the previous report's value.
- R6: `restart` is updated at every report. It is high for the first report after reset, after deblocking, after re-enabling and after a change of `cycle_sel`; otherwise it is low.
- R7: The accumulator wraps from all-ones to zero. The report covering the wrap has `restart` high, and the following report without a wrap has it low.
- R8: `xmit_req` held high across two ticks gives exactly one extra report per high period, and it does not shift the periodic report schedule.
- R9: `xmit_req` high for less than two ticks produces no report.
- R10: `invalid` is high exactly while `mod_fail` or `mod_misconf` is high.
- R11: With `op_enable` low there is no counting and no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-second tick enable, one cycle wide |
| op_enable | input | 1 | Function on/off |
| cycle_sel | input | 4 | Integration cycle code (R3) |
| pulse_in | input | 1 | Asynchronous counted pulse input |
| block_cmd | input | 1 | Block counting |
| xmit_req | input | 1 | Extra-reading request |
| mod_fail | input | 1 | Input module failed |
| mod_misconf | input | 1 | Input module wrongly configured or connected |
| mod_inop | input | 1 | Input module inoperative |
| rep_strobe | output | 1 | One-cycle report marker |
| rep_value | output | CNT_W | Reported total |
| new_val | output | 1 | Value changed since last report |
| restart | output | 1 | Report is not a full wrap-free cycle |
| blocked | output | 1 | Counting blocked |
| invalid | output | 1 | Input module unhealthy |

## Verification
Four properties are checked on every cycle: the accumulator is frozen while blocked, nothing is reported while the function is off, `new_val` occurs only with a strobe and never on an unchanged value, and the cycle timer stays below the selected period. The bench scenarios are the only evidence for the rest: the exact report spacing for several cycle codes, the restart marking after start-up, deblocking, re-enabling, code changes and wraps, and the acceptance or rejection of extra-reading requests by their length.

// File: rtl/pulse_integrator.sv
module pulse_integrator #(
  parameter int CNT_W  = 32,
  parameter int TMR_W  = 12,
  parameter int SYNC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1s,
  input  logic             op_enable,
  input  logic [3:0]       cycle_sel,
  input  logic             pulse_in,
  input  logic             block_cmd,
  input  logic             xmit_req,
  input  logic             mod_fail,
  input  logic             mod_misconf,
  input  logic             mod_inop,
  output logic             rep_strobe,
  output logic [CNT_W-1:0] rep_value,
  output logic             new_val,
  output logic             restart,
  output logic             blocked,
  output logic             invalid
);

  function automatic logic [TMR_W-1:0] period_of(input logic [3:0] code);
    case (code)
      4'd0:    period_of = TMR_W'(30);
      4'd1:    period_of = TMR_W'(60);
      4'd2:    period_of = TMR_W'(90);
      4'd3:    period_of = TMR_W'(120);
      4'd4:    period_of = TMR_W'(150);
      4'd5:    period_of = TMR_W'(180);
      4'd6:    period_of = TMR_W'(240);
      4'd7:    period_of = TMR_W'(300);
      4'd8:    period_of = TMR_W'(360);
      4'd9:    period_of = TMR_W'(450);
      4'd10:   period_of = TMR_W'(600);
      4'd11:   period_of = TMR_W'(720);
      4'd12:   period_of = TMR_W'(900);
      4'd13:   period_of = TMR_W'(1200);
      4'd14:   period_of = TMR_W'(1800);
      default: period_of = TMR_W'(3600);
    endcase
  endfunction

  logic [SYNC_W:0]    p_sh;
  logic [SYNC_W-1:0]  x_sh;
  logic [CNT_W-1:0]   acc;
  logic [TMR_W-1:0]   tmr;
  logic [TMR_W-1:0]   per;
  logic [3:0]         sel_q;
  logic [1:0]         x_ticks;
  logic               x_done;
  logic               restart_pend;
  logic               wrap_flag;

  assign blocked = block_cmd | mod_inop;
  assign invalid = mod_fail | mod_misconf;
  assign per     = period_of(sel_q);

  wire run      = op_enable & ~blocked;
  wire sel_chg  = cycle_sel != sel_q;
  wire p_edge   = p_sh[SYNC_W-1] & ~p_sh[SYNC_W];
  wire x_lvl    = x_sh[SYNC_W-1];
  wire inc      = run & p_edge;
  wire wrap_now = inc & (&acc);
  wire per_end  = run & ~sel_chg & tick_1s & (tmr == per - TMR_W'(1));
  wire dem_fire = x_lvl & tick_1s & ~x_done & (x_ticks == 2'd1);
  wire rpt      = op_enable & (per_end | dem_fire);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_sh  <= '0;
      x_sh  <= '0;
      sel_q <= '0;
    end else begin
      p_sh  <= {p_sh[SYNC_W-1:0], pulse_in};
      x_sh  <= {x_sh[SYNC_W-2:0], xmit_req};
      sel_q <= cycle_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   acc <= '0;
    else if (inc) acc <= acc + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || sel_chg) tmr <= '0;
    else if (tick_1s)              tmr <= per_end ? '0 : tmr + TMR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !x_lvl) begin
      x_ticks <= '0;
      x_done  <= 1'b0;
    end else if (tick_1s && !x_done) begin
      if (x_ticks == 2'd1) x_done  <= 1'b1;
      else                 x_ticks <= x_ticks + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      restart_pend <= 1'b1;
      wrap_flag    <= 1'b0;
    end else begin
      if (!run || sel_chg) restart_pend <= 1'b1;
      else if (rpt)        restart_pend <= 1'b0;
      wrap_flag <= rpt ? wrap_now : (wrap_flag | wrap_now);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_strobe <= 1'b0;
      rep_value  <= '0;
      new_val    <= 1'b0;
      restart    <= 1'b0;
    end else begin
      rep_strobe <= rpt;
      new_val    <= rpt & (acc != rep_value);
      if (rpt) begin
        rep_value <= acc;
        restart   <= restart_pend | wrap_flag;
      end
    end
  end

endmodule

// File: rtl/pulse_integrator_chk.sv
module pulse_integrator_chk #(
  parameter int CNT_W = 32,
  parameter int TMR_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_enable,
  input logic             blocked,
  input logic             rep_strobe,
  input logic             new_val,
  input logic [CNT_W-1:0] rep_value,
  input logic [CNT_W-1:0] acc,
  input logic [TMR_W-1:0] tmr,
  input logic [TMR_W-1:0] per
);

  AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) blocked |=> acc == $past(acc)); // R2
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tmr < per); // R3
  AST_NEWVAL_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n) new_val |-> rep_strobe); // R5
  AST_SAME_VALUE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (rep_strobe && !new_val) |-> rep_value == $past(rep_value)); // R5
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !op_enable |=> !rep_strobe); // R11

endmodule

bind pulse_integrator pulse_integrator_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_enable(op_enable), .blocked(blocked),
  .rep_strobe(rep_strobe), .new_val(new_val), .rep_value(rep_value),
  .acc(acc), .tmr(tmr), .per(per)
);

// File: tb/pulse_integrator_test.sv
module pulse_integrator_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int W          = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick_1s = 1'b0, op_enable = 1'b1;
  logic [3:0] cycle_sel = 4'd0;
  logic pulse_in = 1'b0, block_cmd = 1'b0, xmit_req = 1'b0;
  logic mod_fail = 1'b0, mod_misconf = 1'b0, mod_inop = 1'b0;
  logic rep_strobe, new_val, restart, blocked, invalid;
  logic [W-1:0] rep_value;

  pulse_integrator #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .op_enable(op_enable),
    .cycle_sel(cycle_sel), .pulse_in(pulse_in), .block_cmd(block_cmd),
    .xmit_req(xmit_req), .mod_fail(mod_fail), .mod_misconf(mod_misconf),
    .mod_inop(mod_inop), .rep_strobe(rep_strobe), .rep_value(rep_value),
    .new_val(new_val), .restart(restart), .blocked(blocked), .invalid(invalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, checks = 0, errors = 0;
  int rep_cnt = 0, r_time = 0, r_prev = 0, r_val = 0;
  bit r_rst, r_new;

  always @(posedge clk) cyc++;
  always @(negedge clk) tick_1s <= (cyc % TICK_DIV) == 0;
  always @(negedge clk)
    if (rst_n && rep_strobe) begin
      rep_cnt++;
      r_val = int'(rep_value);
      r_rst = restart;
      r_new = new_val;
      r_prev = r_time;
      r_time = cyc;
    end

  function automatic int period_ticks(input int code);
    int tbl[16] = '{30, 60, 90, 120, 150, 180, 240, 300, 360, 450, 600, 720, 900, 1200, 1800, 3600};
    return tbl[code];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pulse_in = 1'b1; repeat (2) @(negedge clk);
      pulse_in = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_rep(input int lim, output bit got);
    int c0 = rep_cnt;
    got = 0;
    for (int i = 0; i < lim && !got; i++) begin
      @(negedge clk); #1;
      if (rep_cnt != c0) got = 1;
    end
  endtask

  task automatic expect_report(input string req, input int lim, input int val, input bit rs, input bit nw);
    bit got;
    wait_rep(lim, got);
    check(got, {req, " report present"}, int'(got), 1);
    check(r_val == val, {req, " value"}, r_val, val);
    check(r_rst == rs, {req, " restart"}, int'(r_rst), int'(rs));
    check(r_new == nw, {req, " new_val"}, int'(r_new), int'(nw));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int exp_v, n, c0, t_per, k;
    bit got;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rep_strobe == 0 && new_val == 0 && rep_value == 0, "R4 reset", int'(rep_value), 0);
    check(blocked == 0 && invalid == 0, "R10 reset", int'(invalid), 0);

    pulses(5); exp_v = 5;
    expect_report("R1 R6 first", 300, exp_v, 1, 1);

    for (int it = 0; it < 6; it++) begin
      n = $urandom_range(0, 6);
      pulses(n); exp_v += n;
      expect_report("R1 R4 R5", 200, exp_v, 0, n != 0);
      check(r_time - r_prev == 30 * TICK_DIV, "R3 gap code0", r_time - r_prev, 30 * TICK_DIV);
    end

    block_cmd = 1'b1; @(negedge clk); #1;
    check(blocked == 1, "R2 blocked level", int'(blocked), 1);
    pulses(3);
    wait_rep(300, got);
    check(!got, "R2 no report while blocked", int'(got), 0);
    block_cmd = 1'b0;
    expect_report("R2 R6 deblock", 200, exp_v, 1, 0);

    mod_inop = 1'b1; @(negedge clk); #1;
    check(blocked == 1, "R2 inop blocks", int'(blocked), 1);
    pulses(2);
    mod_inop = 1'b0;
    expect_report("R2 R6 inop release", 200, exp_v, 1, 0);

    mod_fail = 1'b1; #1;
    check(invalid == 1, "R10 fail", int'(invalid), 1);
    mod_fail = 1'b0; mod_misconf = 1'b1; #1;
    check(invalid == 1, "R10 misconf", int'(invalid), 1);
    mod_misconf = 1'b0; #1;
    check(invalid == 0, "R10 clear", int'(invalid), 0);

    expect_report("R4 periodic", 200, exp_v, 0, 0);
    t_per = r_time;
    pulses(2); exp_v += 2;
    c0 = rep_cnt;
    xmit_req = 1'b1; repeat (16) @(negedge clk);
    xmit_req = 1'b0; repeat (4) @(negedge clk); #1;
    check(rep_cnt == c0 + 1, "R8 one extra report", rep_cnt - c0, 1);
    check(r_val == exp_v && r_new == 1 && r_rst == 0, "R8 extra value", r_val, exp_v);
    expect_report("R8 periodic after demand", 200, exp_v, 0, 0);
    check(r_time - t_per == 30 * TICK_DIV, "R8 schedule kept", r_time - t_per, 30 * TICK_DIV);

    c0 = rep_cnt;
    xmit_req = 1'b1; repeat (2) @(negedge clk);
    xmit_req = 1'b0; repeat (30) @(negedge clk); #1;
    check(rep_cnt == c0, "R9 short request ignored", rep_cnt - c0, 0);
    expect_report("R9 periodic", 200, exp_v, 0, 0);

    op_enable = 1'b0;
    pulses(3);
    wait_rep(300, got);
    check(!got, "R11 silent when off", int'(got), 0);
    op_enable = 1'b1;
    expect_report("R11 R6 re-enable", 200, exp_v, 1, 0);

    cycle_sel = 4'd7;
    expect_report("R6 code change", 1500, exp_v, 1, 0);
    k = (1 << W) - exp_v + 3;
    pulses(k); exp_v = 3;
    expect_report("R7 wrap", 1500, exp_v, 1, 1);
    expect_report("R7 after wrap", 1500, exp_v, 0, 0);
    check(r_time - r_prev == period_ticks(7) * TICK_DIV, "R3 gap code7", r_time - r_prev, period_ticks(7) * TICK_DIV);

    cycle_sel = 4'd1;
    expect_report("R6 code1", 1000, exp_v, 1, 0);
    expect_report("R3 code1", 1000, exp_v, 0, 0);
    check(r_time - r_prev == period_ticks(1) * TICK_DIV, "R3 gap code1", r_time - r_prev, period_ticks(1) * TICK_DIV);

    cycle_sel = 4'd9;
    expect_report("R6 code9", 2000, exp_v, 1, 0);
    expect_report("R3 code9", 2000, exp_v, 0, 0);
    check(r_time - r_prev == period_ticks(9) * TICK_DIV, "R3 gap code9", r_time - r_prev, period_ticks(9) * TICK_DIV);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule